// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps external events against a free-running timer. It watches one of two event inputs: a capture pin, or the output of an analog comparator. When the chosen input makes a level change in the configured direction, the block copies the current timer count into a capture register. In the same clock cycle it raises a capture flag. The counter, the comparator and the waveform logic that might use the capture register as a period limit all sit outside the block. The counter value arrives on an input port.

The selected input first passes through a two-stage synchronizer. It can then go through an optional noise filter before edge detection. The filter needs four equal consecutive samples before it accepts a new level.

Software reaches the block over an 8-bit bus. A 16-bit capture value is read low byte first. That read latches the high byte into a shared temporary register, and a later read of the high address returns the temporary register. Both halves therefore come from the same capture, even if a new capture lands between the two reads. The flag drives an interrupt request when interrupts are enabled. The flag is cleared by an acknowledge pulse or by writing a one to it.

Top module: `tmr_capture_unit`

## Requirements
- R1: With `src_sel`=0 the capture pin is the event source and with `src_sel`=1 the comparator input is. Level changes on the input that is not selected cause no capture and leave the capture register unchanged.
- R2: With `edge_rise`=1 only a 0-to-1 change of the selected input captures, and with `edge_rise`=0 only a 1-to-0 change captures. A change in the other direction leaves the flag clear and the capture register unchanged.
- R3: With the filter off, an input change that is applied between two clock edges is captured at the third following rising edge. The capture register then holds the `cnt_val` present at that edge.
- R4: The capture flag rises at the same clock edge that loads the capture register. After reset the flag, `irq` and the capture register are all zero.
- R5: `irq` is 1 exactly when the flag is set and `irq_en` was 1 at the edge that last updated the flag.
- R6: An `irq_ack` pulse clears the flag. A bus write to address 2 with data bit 0 set also clears it. A write to address 2 with bit 0 clear does not change the flag.
- R7: If a capture and a clear request arrive at the same clock edge, the flag is left set.
- R8: A read of address 0 returns the capture register's low byte one cycle later, and the same read copies the high byte into the temporary register. A read of address 1 returns the temporary register, so a capture between the two reads does not change the high byte returned. A read of address 2 returns the flag in bit 0.
- R9: A write to address 1 loads the temporary register. With `top_mode`=1, a write to address 0 loads the capture register with {temporary, written byte}. With `top_mode`=0, a write to address 0 leaves the capture register unchanged.
- R10: With `filt_en`=1, a level change reaches the edge detector only after four consecutive equal samples, which delays the capture by four more cycles than in R3. A pulse shorter than four cycles causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current value of the external timer counter |
| pin_in | input | 1 | External capture pin, asynchronous |
| cmp_in | input | 1 | Analog comparator output, asynchronous |
| src_sel | input | 1 | Event source select: 0 pin, 1 comparator |
| filt_en | input | 1 | Noise filter enable |
| edge_rise | input | 1 | Edge polarity: 1 rising, 0 falling |
| irq_en | input | 1 | Capture interrupt enable |
| top_mode | input | 1 | Capture register is used as counter limit; allows bus writes to it |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered bus read data, valid the cycle after a read |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
Some properties are checked on every cycle. A capture sets the flag and loads exactly the sampled counter value on one edge. A capture always beats a clear. An acknowledge without a capture clears the flag. `irq` never stands without the flag. The capture register holds its value when it is neither captured into nor writable. The filter output only moves to a level its input has already shown, and each capture event agrees with the selected polarity. Other behaviour needs the bench's scenarios. These include the exact three-cycle and seven-cycle latencies and the rejection of opposite edges and of an unselected source. They also include the suppression of short pulses, and the atomic high-byte read across a capture between the two reads.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;
  localparam int SYNC_STAGES = 2;
  localparam int FILT_SAMPLES = 4;
endpackage

// File: rtl/tcu_sync.sv
module tcu_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcu_filter.sv
module tcu_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic level_o
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist_q;
  logic          filt_q;
  logic          all_eq;

  assign all_eq = (hist_q == {HW{d_i}});

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q[0] <= d_i;
      for (int i = 1; i < HW; i++) begin
        hist_q[i] <= hist_q[i-1];
      end
      if (all_eq) filt_q <= d_i;
    end
  end

  assign level_o = filt_q;

  // R10
  filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(d_i)));
endmodule

// File: rtl/tcu_edge.sv
module tcu_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic rise_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign evt_o = (level_i != prev_q) && (level_i == rise_i);

  // R2
  edge_dir_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> (prev_q == $past(rise_i)));
endmodule

// File: rtl/tcu_regs.sv
module tcu_regs
  import tcu_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_evt,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              top_mode,
  input  logic              irq_en,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cap_flag,
  output logic              irq
);
  logic [CNT_W-1:0] cap_q;
  logic [BUS_W-1:0] temp_q;
  logic [BUS_W-1:0] rdata_q;
  logic             flag_q;
  logic             irq_q;
  logic             flag_n;
  logic             lo_wr, hi_wr, lo_rd, clr_req;

  assign lo_wr   = bus_wr && (bus_addr == ADDR_LO);
  assign hi_wr   = bus_wr && (bus_addr == ADDR_HI);
  assign lo_rd   = bus_rd && (bus_addr == ADDR_LO);
  assign clr_req = irq_ack || (bus_wr && (bus_addr == ADDR_FLAG) && bus_wdata[0]);

  always_comb begin
    flag_n = flag_q;
    if (cap_evt)      flag_n = 1'b1;
    else if (clr_req) flag_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      temp_q  <= '0;
      rdata_q <= '0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (cap_evt)                cap_q <= cnt_val;
      else if (top_mode && lo_wr) cap_q <= {temp_q, bus_wdata};
      if (hi_wr)      temp_q <= bus_wdata;
      else if (lo_rd) temp_q <= cap_q[CNT_W-1:BUS_W];
      flag_q <= flag_n;
      irq_q  <= flag_n && irq_en;
      if (bus_rd) begin
        case (bus_addr)
          ADDR_LO:   rdata_q <= cap_q[BUS_W-1:0];
          ADDR_HI:   rdata_q <= temp_q;
          ADDR_FLAG: rdata_q <= {{(BUS_W-1){1'b0}}, flag_q};
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign cap_flag  = flag_q;
  assign irq       = irq_q;

  // R4
  cap_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (flag_q && (cap_q == $past(cnt_val))));
  // R7
  cap_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && clr_req) |=> flag_q);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !cap_evt) |=> !flag_q);
  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!top_mode && !cap_evt) |=> (cap_q == $past(cap_q)));
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcu_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              pin_in,
  input  logic              cmp_in,
  input  logic              src_sel,
  input  logic              filt_en,
  input  logic              edge_rise,
  input  logic              irq_en,
  input  logic              top_mode,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cap_flag,
  output logic              irq
);
  logic [1:0] sync_lv;
  logic       sel_lv;
  logic       filt_lv;
  logic       det_lv;
  logic       cap_evt;

  tcu_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cmp_in, pin_in}),
    .q_o (sync_lv)
  );

  assign sel_lv = src_sel ? sync_lv[1] : sync_lv[0];

  tcu_filter #(.LEN(FILT_SAMPLES)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .d_i     (sel_lv),
    .level_o (filt_lv)
  );

  assign det_lv = filt_en ? filt_lv : sel_lv;

  tcu_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (det_lv),
    .rise_i  (edge_rise),
    .evt_o   (cap_evt)
  );

  tcu_regs #(.BUS_W(BUS_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cap_evt   (cap_evt),
    .cnt_val   (cnt_val),
    .top_mode  (top_mode),
    .irq_en    (irq_en),
    .irq_ack   (irq_ack),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_flag  (cap_flag),
    .irq       (irq)
  );
endmodule

// File: tb/tmr_capture_unit_bench.sv
`timescale 1ns/1ps
module tmr_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt = 16'h12F0;
  logic [15:0] cnt_step = 16'h0001;
  logic        pin_in = 0, cmp_in = 0, src_sel = 0, filt_en = 0, edge_rise = 1;
  logic        irq_en = 0, top_mode = 0, irq_ack = 0;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        cap_flag, irq;

  int checks = 0;
  int errors = 0;
  logic done = 0;
  logic rd_seen = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + cnt_step;
  always @(posedge clk) rd_seen <= bus_rd;

  tmr_capture_unit u_tmr_capture_unit (
    .clk(clk), .rst(rst), .cnt_val(cnt), .pin_in(pin_in), .cmp_in(cmp_in),
    .src_sel(src_sel), .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en),
    .top_mode(top_mode), .irq_ack(irq_ack), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_flag(cap_flag), .irq(irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when a read result is due
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({8'h00, bus_rdata}, {8'h00, e}, t);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick(1);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1;
    tick(1);
    bus_rd = 0;
    tick(1);
  endtask

  task automatic read16(input logic [15:0] e, input string t);
    bus_read(2'd0, e[7:0], t);
    bus_read(2'd1, e[15:8], t);
  endtask

  logic [15:0] v, held, first;

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R4 reset state
    chk({15'd0, cap_flag}, 16'd0, "R4 reset flag");
    chk({15'd0, irq}, 16'd0, "R5 reset irq");
    read16(16'h0000, "R4 reset capture");

    // R3 unfiltered rising capture from pin
    pin_in = 1; v = cnt;
    tick(2);
    chk({15'd0, cap_flag}, 16'd0, "R3 flag not early");
    tick(1);
    chk({15'd0, cap_flag}, 16'd1, "R4 flag at capture edge");
    held = v + 16'd2;
    read16(held, "R3 captured value");
    bus_read(2'd2, 8'h01, "R8 flag readback");
    // R6 write zero no effect, write one clears
    bus_write(2'd2, 8'h00);
    chk({15'd0, cap_flag}, 16'd1, "R6 write zero keeps flag");
    bus_write(2'd2, 8'h01);
    chk({15'd0, cap_flag}, 16'd0, "R6 write one clears");

    // R2 falling change with rising polarity ignored
    pin_in = 0; tick(8);
    chk({15'd0, cap_flag}, 16'd0, "R2 falling ignored");
    read16(held, "R2 capture unchanged");
    // R2 falling polarity
    edge_rise = 0; tick(2);
    pin_in = 1; tick(8);
    chk({15'd0, cap_flag}, 16'd0, "R2 rising ignored in falling mode");
    pin_in = 0; v = cnt; tick(3);
    chk({15'd0, cap_flag}, 16'd1, "R2 falling captured");
    held = v + 16'd2;
    read16(held, "R2 falling value");
    bus_write(2'd2, 8'h01);

    // R1 comparator source, pin ignored
    src_sel = 1; edge_rise = 1; tick(4);
    pin_in = 1; tick(4); pin_in = 0; tick(6);
    chk({15'd0, cap_flag}, 16'd0, "R1 unselected pin ignored");
    read16(held, "R1 capture unchanged");
    irq_en = 1;
    cmp_in = 1; v = cnt; tick(3);
    chk({15'd0, cap_flag}, 16'd1, "R1 comparator captured");
    chk({15'd0, irq}, 16'd1, "R5 irq with enable");
    held = v + 16'd2;
    read16(held, "R1 comparator value");
    // R6 acknowledge
    irq_ack = 1; tick(1); irq_ack = 0;
    chk({15'd0, cap_flag}, 16'd0, "R6 ack clears flag");
    chk({15'd0, irq}, 16'd0, "R5 irq drops with flag");

    // R7 capture and clear at the same edge
    irq_en = 0;
    cmp_in = 0; tick(6);
    cmp_in = 1; v = cnt; tick(2);
    bus_addr = 2'd2; bus_wdata = 8'h01; bus_wr = 1;
    tick(1);
    bus_wr = 0;
    chk({15'd0, cap_flag}, 16'd1, "R7 capture beats clear");
    chk({15'd0, irq}, 16'd0, "R5 no irq when disabled");
    held = v + 16'd2;
    read16(held, "R7 value");

    // R8 atomic read across a new capture
    cnt_step = 16'h0101;
    first = held;
    bus_read(2'd0, first[7:0], "R8 low byte");
    cmp_in = 0; tick(6);
    cmp_in = 1; v = cnt; tick(4);
    held = v + 16'h0202;
    bus_read(2'd1, first[15:8], "R8 high byte from temp");
    read16(held, "R8 new capture");
    cnt_step = 16'h0001;

    // R9 writes ignored without top mode, taken with it
    bus_write(2'd1, 8'hAB);
    bus_write(2'd0, 8'hCD);
    read16(held, "R9 write ignored");
    top_mode = 1;
    bus_write(2'd1, 8'h5A);
    bus_write(2'd0, 8'hA5);
    top_mode = 0;
    read16(16'h5AA5, "R9 write taken");
    bus_write(2'd2, 8'h01);

    // R10 filter: short pulse rejected, long pulse delayed by four
    src_sel = 0; pin_in = 0; cmp_in = 0; tick(8);
    filt_en = 1; tick(8);
    pin_in = 1; tick(3); pin_in = 0; tick(10);
    chk({15'd0, cap_flag}, 16'd0, "R10 short pulse rejected");
    read16(16'h5AA5, "R10 capture unchanged");
    pin_in = 1; v = cnt; tick(6);
    chk({15'd0, cap_flag}, 16'd0, "R10 not before filter delay");
    tick(1);
    chk({15'd0, cap_flag}, 16'd1, "R10 filtered capture");
    read16(v + 16'd6, "R10 filtered value");

    tick(4);
    chk(exp_q.size(), 16'd0, "scoreboard drained");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule